// File: doc/BRIEF.md
# Dual-format serial audio receiver

This block deserializes stereo PCM audio from a three-wire serial port: a bit clock, a frame clock that marks the channel, and one data line. It runs entirely in the bit-clock domain. Frame clock and data are both sampled on the rising bit-clock edge. A static format input selects one of two framings. In I2S framing the first data bit follows the frame-clock edge by one bit period. In left-justified framing it lines up with that edge.

Each channel slot is turned into a two's complement word of up to 24 bits, aligned to the MSB. Bits past the word width are dropped. A short slot is filled with zeros at the LSB end. Once the right slot of a frame has ended, the left and right words are shown together with a one-cycle strobe. After reset that strobe only appears for a frame whose two slots were both seen from their first bit.

Top module: `pcm_serial_rx`

## Requirements
- R1: With `fmt_lj_i` = 0 (I2S), frame clock low marks the left slot. The MSB of a slot is the data bit sampled on the second rising edge after a frame-clock transition.
- R2: With `fmt_lj_i` = 1 (left-justified), frame clock high marks the left slot. The MSB of a slot is the data bit sampled on the first rising edge after a frame-clock transition.
- R3: The first bit received in a slot lands in output bit 23, and later bits fill downwards, so a two's complement sample comes out bit for bit unchanged.
- R4: Bits past the 24th in a slot have no effect on the output word.
- R5: A slot of N < 24 bits yields the N received bits in bits 23 down to 24-N, with zeros below.
- R6: `valid_o` is high for exactly one cycle per complete frame. It appears in the cycle after the rising edge that detects the start of the next left slot. `left_o` and `right_o` change only in that cycle.
- R7: While `rst_ni` is low, `left_o` and `right_o` are zero and `valid_o` is low. After reset, no strobe appears until a left slot and the right slot after it have each been received from their first bit.
- R8: Slots of up to 64 bit periods (128 per frame) are handled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_lj_i | input | 1 | Static framing select: 0 = I2S, 1 = left-justified |
| lrck_i | input | 1 | Frame clock, selects the channel |
| sdin_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, two's complement, MSB aligned |
| right_o | output | 24 | Right sample, two's complement, MSB aligned |
| valid_o | output | 1 | One-cycle strobe for a new left/right pair |

## Verification
A pair is due in one specific bit period.

- **Left-justified:** it is the period in which the driver raises the frame clock for the next left slot, because the strobe registers on the rising edge inside that period.
- **I2S:** it is one period later, because the format adds one register of delay.

The driver raises a per-period "due" flag in exactly that period. A monitor samples a quarter period after each rising edge and requires the strobe to match the flag. On each strobe the monitor pops the queued expected pair and compares both words against the sample, truncated or zero-padded to the slot length.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } fmt_e;

  // edges after reset before frame-clock history is trusted
  localparam int unsigned WARM_CYCLES = 2;
endpackage

// File: rtl/pcm_rx_frame.sv
module pcm_rx_frame
  import pcm_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  fmt_e fmt_i,
  input  logic lrck_i,
  output logic start_o,
  output logic prev_left_o
);
  localparam logic [1:0] WARM_DONE = 2'(WARM_CYCLES);

  logic       lr_q;
  logic       ch_q;
  logic       ch_d;
  logic [1:0] warm_q;

  // I2S: use frame clock delayed one bit so the slot start hits the MSB
  always_comb begin
    ch_d        = (fmt_i == FMT_LJ) ? lrck_i : lr_q;
    prev_left_o = (fmt_i == FMT_LJ) ? ch_q : ~ch_q;
    start_o     = (warm_q == WARM_DONE) && (ch_d != ch_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q   <= 1'b0;
      ch_q   <= 1'b0;
      warm_q <= '0;
    end else begin
      lr_q <= lrck_i;
      ch_q <= ch_d;
      if (warm_q != WARM_DONE) warm_q <= warm_q + 2'd1;
    end
  end

  AST_LJ_START_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && fmt_i == FMT_LJ) |-> (lrck_i != $past(lrck_i))); // R2

  AST_I2S_START_DELAYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && fmt_i == FMT_I2S) |-> ($past(lrck_i) != $past(lrck_i, 2))); // R1
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                bit_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                word_ok_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] word_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
    end else if (start_i) begin
      word_q <= {bit_i, {(SAMPLE_W-1){1'b0}}};
      cnt_q  <= CNT_W'(1);
      ok_q   <= 1'b1;
    end else if (cnt_q != CNT_FULL) begin
      for (int i = 0; i < SAMPLE_W; i++) begin
        if (cnt_q == CNT_W'(SAMPLE_W - 1 - i)) word_q[i] <= bit_i;
      end
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign word_o    = word_q;
  assign word_ok_o = ok_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R4

  AST_MSB_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CNT_W'(1)) && (word_q[SAMPLE_W-1] == $past(bit_i))); // R3

  AST_LSB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (word_q[SAMPLE_W-2:0] == '0)); // R5
endmodule

// File: rtl/pcm_rx_pair.sv
module pcm_rx_pair #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                prev_left_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                word_ok_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] hold_q;
  logic                hold_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      hold_ok_q <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        if (prev_left_i) begin
          hold_q    <= word_i;
          hold_ok_q <= word_ok_i;
        end else begin
          if (hold_ok_q && word_ok_i) begin
            left_o  <= hold_q;
            right_o <= word_i;
            valid_o <= 1'b1;
          end
          hold_ok_q <= 1'b0;
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R6

  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i)); // R6
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fmt_lj_i,
  input  logic                lrck_i,
  input  logic                sdin_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic                start;
  logic                prev_left;
  logic [SAMPLE_W-1:0] word;
  logic                word_ok;
  fmt_e                fmt;

  assign fmt = fmt_e'(fmt_lj_i);

  pcm_rx_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fmt_i       (fmt),
    .lrck_i      (lrck_i),
    .start_o     (start),
    .prev_left_o (prev_left)
  );

  pcm_rx_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .bit_i     (sdin_i),
    .word_o    (word),
    .word_ok_o (word_ok)
  );

  pcm_rx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .prev_left_i (prev_left),
    .word_i      (word),
    .word_ok_i   (word_ok),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );
endmodule

// File: tb/pcm_serial_rx_test.sv
module pcm_serial_rx_test;
  localparam int CLK_P = 10;
  localparam int W     = 24;

  logic         clk_i    = 1'b0;
  logic         rst_ni   = 1'b1;
  logic         fmt_lj_i = 1'b0;
  logic         lrck_i   = 1'b0;
  logic         sdin_i   = 1'b0;
  logic [W-1:0] left_o;
  logic [W-1:0] right_o;
  logic         valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit prev_bit = 1'b0;
  bit pending  = 1'b0;
  bit exp_now  = 1'b0;

  typedef struct {
    logic [W-1:0] l;
    logic [W-1:0] r;
    string        tag;
  } exp_t;
  exp_t sb[$];

  pcm_serial_rx #(.SAMPLE_W(W)) uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fmt_lj_i (fmt_lj_i),
    .lrck_i   (lrck_i),
    .sdin_i   (sdin_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [W-1:0] trunc(input logic [W-1:0] v, input int n);
    if (n >= W) return v;
    return v & ~({W{1'b1}} >> n);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one channel slot of n bit periods; bits past W carry a filler pattern
  task automatic send_slot(input bit left, input logic [W-1:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      bit b;
      b = (k < W) ? v[W-1-k] : ((k % 2) == 1);
      @(negedge clk_i);
      lrck_i   = fmt_lj_i ? left : ~left;
      sdin_i   = fmt_lj_i ? b : prev_bit;
      prev_bit = b;
      exp_now  = 1'b0;
      if (left && pending && k == (fmt_lj_i ? 0 : 1)) begin
        exp_now = 1'b1;
        pending = 1'b0;
      end
    end
  endtask

  task automatic send_frame(input logic [W-1:0] l, input logic [W-1:0] r,
                            input int n, input string tag);
    send_slot(1'b1, l, n);
    send_slot(1'b0, r, n);
    sb.push_back('{trunc(l, n), trunc(r, n), tag});
    pending = 1'b1;
  endtask

  task automatic flush();
    send_slot(1'b1, '0, 4);
    repeat (3) @(negedge clk_i);
    exp_now = 1'b0;
  endtask

  task automatic do_reset(input bit fmt, input bit idle_left);
    @(negedge clk_i);
    rst_ni   = 1'b0;
    fmt_lj_i = fmt;
    lrck_i   = fmt ? idle_left : ~idle_left;
    sdin_i   = 1'b0;
    prev_bit = 1'b0;
    pending  = 1'b0;
    exp_now  = 1'b0;
    repeat (2) @(negedge clk_i);
    check(left_o == '0,  "R7 reset left",  left_o,  '0);
    check(right_o == '0, "R7 reset right", right_o, '0);
    check(valid_o == 1'b0, "R7 reset valid", W'(valid_o), '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  // scoreboard monitor: samples a quarter period after each rising edge
  always @(posedge clk_i) begin
    #(CLK_P/4);
    if (rst_ni && (exp_now || valid_o)) begin
      check(valid_o == exp_now, "R6 strobe timing", W'(valid_o), W'(exp_now));
      if (valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 strobe with no pair pending", W'(valid_o), '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(left_o == e.l,  {e.tag, " left"},  left_o,  e.l);
          check(right_o == e.r, {e.tag, " right"}, right_o, e.r);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;

    // I2S, 32-bit slots: delayed MSB, overlong slots truncated (R1, R3, R4)
    do_reset(1'b0, 1'b0);
    send_frame(24'h123456, 24'hABCDEF, 32, "R1 R4");
    send_frame(24'h800001, 24'h7FFFFF, 32, "R1 R3");
    send_frame(24'hFFFFFF, 24'h000000, 32, "R1 R4");
    // I2S, 24-bit slots, negative samples
    send_frame(24'hC0FFEE, 24'h9ABCDE, 24, "R1 R3");
    send_frame(24'h000001, 24'h800000, 24, "R1 R3");
    flush();

    // left-justified (R2, R3, R5, R8)
    do_reset(1'b1, 1'b0);
    send_frame(24'hA5A5A5, 24'h5A5A5A, 24, "R2 R3");
    send_frame(24'hFEDCBA, 24'h13579B, 16, "R5 16-bit");
    send_frame(24'h8F1234, 24'h7E5678, 8,  "R5 8-bit");
    send_frame(24'h654321, 24'hF00F0F, 64, "R8 R4 64-bit");
    send_frame(24'h2468AC, 24'hDB9753, 64, "R8 R4 64-bit");
    flush();

    // reset in mid left slot: first partial frame must not strobe (R7)
    do_reset(1'b1, 1'b1);
    send_slot(1'b0, 24'h5A5A5A, 20);
    send_frame(24'h0F0F0F, 24'hF0F0F0, 24, "R7 first full frame");
    flush();

    check(sb.size() == 0, "R6 every pair delivered", W'(sb.size()), '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule